// File: doc/BRIEF.md
# Pruned Bit-Reversal Interleaver Address Generator

This block produces the address sequence for a channel interleaver whose packet length `L` does not have to be a power of two. A start pulse latches `L` and derives the order `n`, the smallest value with `L <= 2^n`. The block then walks a candidate index `j` upward from zero. Each candidate is bit-reversed over `n` bits. Any reversed value that is not below `L` is dropped, and the surviving values are streamed out one per clock, with a valid/ready handshake and a last flag on the final address.

A plain pruned walk must stop whenever a candidate is dropped. This block avoids that by testing `j` and `j+1` in the same cycle. When `L > 2^(n-1)`, every even candidate reverses to a value below `2^(n-1)`, so it always survives. As a result, at most one dropped candidate sits between two kept ones, and a two-wide lookahead always finds an address. The counter then moves forward by one or two. The consumer of the stream, for example a memory write or read port, sees exactly `L` addresses back to back whenever it holds ready high.

Top module: `prune_brev_agen`

## Requirements
- R1: On an accepted start, the order is the smallest `n` with `len_i <= 2^n`. Every emitted address is the `n`-bit bit-reversal of a candidate index: bit `i` of the address equals bit `n-1-i` of the candidate.
- R2: Only reversed values strictly below `L` are emitted, and each appears once. The k-th emitted address is the k-th surviving value when candidates are taken in ascending order from 0.
- R3: Exactly `L` addresses are emitted. `last_o` is high with the L-th address and low with all others. After the handshake of that address, `busy_o` and `valid_o` fall on the next clock edge.
- R4: While `ready_i` stays high, `valid_o` stays high on every cycle from the first address through the L-th. No cycle is lost to a dropped candidate.
- R5: While `valid_o` is high and `ready_i` is low, `addr_o`, `last_o` and `valid_o` hold their values, and no address is skipped or repeated once `ready_i` returns.
- R6: A start pulse that arrives while `busy_o` is high is ignored. The running sequence continues unchanged.
- R7: A start pulse with `len_i` below 2 or above `2^ADDR_W` is ignored, and `busy_o` and `valid_o` stay low.
- R8: When `L` is a power of two, nothing is dropped. The k-th address is the `log2(L)`-bit reversal of k.
- R9: Out of reset, `valid_o`, `last_o` and `busy_o` are low.
- R10: `busy_o` rises on the clock edge that accepts the start. The first address appears with `valid_o` on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle and the length is legal |
| len_i | input | ADDR_W+1 | Packet length L, from 2 to 2^ADDR_W |
| ready_i | input | 1 | Consumer accepts the current address |
| busy_o | output | 1 | A packet is being generated or drained |
| valid_o | output | 1 | `addr_o` holds a valid interleaved address |
| last_o | output | 1 | The current address is the final one of the packet |
| addr_o | output | ADDR_W | Interleaved address |

## Verification
On every cycle, the checker confirms several properties. It checks that a held address stays frozen during backpressure and that no address at or above the latched length is presented. It also checks that a stream with ready held high has no gap, that the last handshake returns the block to idle, and that the latched length cannot change while busy. Illegal lengths and starts during a packet must leave the state untouched. Two things are visible only to the bench's sweep, which compares every packet against an arithmetically built reference. The first is whether the sequence is the correct pruned permutation in the correct order. The second is whether exactly `L` addresses arrive. The sweep covers every length on a small configuration, and selected lengths under irregular backpressure and under restart attempts.

// File: rtl/brev_agen_pkg.sv
package brev_agen_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } agen_state_e;

   // number of candidates examined per cycle by the lookahead
   localparam int unsigned LOOKAHEAD = 2;

endpackage

// File: rtl/brev_order_calc.sv
module brev_order_calc #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned LEN_W  = ADDR_W + 1,
   parameter int unsigned ORD_W  = $clog2(ADDR_W + 1)
) (
   input  logic [LEN_W-1:0] len_i,
   output logic [ORD_W-1:0] order_o,
   output logic             len_ok_o
);

   localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);
   localparam logic [LEN_W-1:0] MAX_LEN = {1'b1, {ADDR_W{1'b0}}};

   logic [LEN_W-1:0] len_m1;

   assign len_m1 = len_i - LEN_W'(1);

   // order = bit length of (L-1): smallest n with L <= 2^n
   always_comb begin
      order_o = '0;
      for (int i = 0; i < ADDR_W; i++) begin
         if ((len_m1 >> i) != '0) order_o = ORD_W'(i + 1);
      end
   end

   assign len_ok_o = (len_i >= MIN_LEN) && (len_i <= MAX_LEN);

endmodule

// File: rtl/brev_reverse.sv
module brev_reverse #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned ORD_W  = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] idx_i,
   input  logic [ORD_W-1:0]  order_i,
   output logic [ADDR_W-1:0] rev_o
);

   localparam logic [ORD_W-1:0] FULL_ORD = ORD_W'(ADDR_W);

   logic [ADDR_W-1:0] full_rev;
   logic [ORD_W-1:0]  shamt;

   // mirror all ADDR_W bits, then drop the unused low end
   for (genvar b = 0; b < ADDR_W; b++) begin : g_mirror
      assign full_rev[b] = idx_i[ADDR_W-1-b];
   end

   assign shamt = FULL_ORD - order_i;
   assign rev_o = full_rev >> shamt;

endmodule

// File: rtl/brev_pick.sv
module brev_pick
   import brev_agen_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned LEN_W  = ADDR_W + 1,
   parameter int unsigned ORD_W  = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] cand_i,
   input  logic [ORD_W-1:0]  order_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        step_o
);

   logic [ADDR_W-1:0] rev_v [LOOKAHEAD];
   logic [LOOKAHEAD-1:0] keep_v;

   for (genvar k = 0; k < LOOKAHEAD; k++) begin : g_cand
      logic [ADDR_W-1:0] idx_k;
      assign idx_k = cand_i + ADDR_W'(k);

      brev_reverse #(
         .ADDR_W (ADDR_W),
         .ORD_W  (ORD_W)
      ) u_rev (
         .idx_i   (idx_k),
         .order_i (order_i),
         .rev_o   (rev_v[k])
      );

      assign keep_v[k] = ({1'b0, rev_v[k]} < len_i);
   end

   // the second candidate is taken only when the first is pruned;
   // it is guaranteed to survive because one of the two is even
   always_comb begin
      if (keep_v[0]) begin
         addr_o = rev_v[0];
         step_o = 2'd1;
      end else begin
         addr_o = rev_v[1];
         step_o = 2'd2;
      end
   end

endmodule

// File: rtl/prune_brev_agen.sv
module prune_brev_agen
   import brev_agen_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W:0]   len_i,
   input  logic              ready_i,
   output logic              busy_o,
   output logic              valid_o,
   output logic              last_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned LEN_W = ADDR_W + 1;
   localparam int unsigned ORD_W = $clog2(ADDR_W + 1);

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_width
      $error("prune_brev_agen: ADDR_W out of supported range");
   end
   if (LOOKAHEAD != 2) begin : g_bad_lookahead
      $error("prune_brev_agen: lookahead must be two candidates");
   end

   agen_state_e       state_q;
   logic [LEN_W-1:0]  len_r;
   logic [ORD_W-1:0]  ord_r;
   logic [ADDR_W-1:0] cand_r;
   logic [LEN_W-1:0]  left_r;

   logic [ORD_W-1:0]  ord_in;
   logic              len_ok;
   logic [ADDR_W-1:0] pick_addr;
   logic [1:0]        pick_step;
   logic              accept;
   logic              load;
   logic              final_load;

   brev_order_calc #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .ORD_W  (ORD_W)
   ) u_order (
      .len_i    (len_i),
      .order_o  (ord_in),
      .len_ok_o (len_ok)
   );

   brev_pick #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .ORD_W  (ORD_W)
   ) u_pick (
      .cand_i  (cand_r),
      .order_i (ord_r),
      .len_i   (len_r),
      .addr_o  (pick_addr),
      .step_o  (pick_step)
   );

   assign accept     = (state_q == ST_IDLE) && start_i && len_ok;
   assign load       = (state_q == ST_RUN) && (!valid_o || ready_i);
   assign final_load = load && (left_r == LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_r   <= '0;
         ord_r   <= '0;
         cand_r  <= '0;
         left_r  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  len_r   <= len_i;
                  ord_r   <= ord_in;
                  cand_r  <= '0;
                  left_r  <= len_i;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (load) begin
                  cand_r <= cand_r + ADDR_W'(pick_step);
                  left_r <= left_r - LEN_W'(1);
                  if (final_load) state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (ready_i) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         last_o  <= 1'b0;
         addr_o  <= '0;
      end else if (load) begin
         valid_o <= 1'b1;
         last_o  <= final_load;
         addr_o  <= pick_addr;
      end else if (valid_o && ready_i) begin
         valid_o <= 1'b0;
         last_o  <= 1'b0;
      end
   end

   assign busy_o = (state_q != ST_IDLE);

endmodule

module prune_brev_agen_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W:0]   len_i,
   input logic              ready_i,
   input logic              busy_o,
   input logic              valid_o,
   input logic              last_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic [ADDR_W:0]   len_r
);

   localparam logic [ADDR_W:0] TOP_LEN = {1'b1, {ADDR_W{1'b0}}};

   logic bad_len;
   assign bad_len = (len_i < (ADDR_W + 1)'(2)) || (len_i > TOP_LEN);

   AST_ADDR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ({1'b0, addr_o} < len_r)); // R2

   AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i && last_o) |=> (!busy_o && !valid_o)); // R3

   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> busy_o); // R3

   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i && !last_o) |=> valid_o); // R4

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(last_o))); // R5

   AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(len_r)); // R6

   AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && bad_len) |=> (!busy_o && !valid_o)); // R7

   AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !valid_o); // R10

endmodule

bind prune_brev_agen prune_brev_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .len_i   (len_i),
   .ready_i (ready_i),
   .busy_o  (busy_o),
   .valid_o (valid_o),
   .last_o  (last_o),
   .addr_o  (addr_o),
   .len_r   (len_r)
);

// File: tb/sim_prune_brev_agen.sv
`timescale 1ns/1ps
module sim_prune_brev_agen;

   localparam int AW   = 6;
   localparam int MAXM = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW:0]   len_i = '0;
   logic          ready_i = 1'b0;
   logic          busy_o, valid_o, last_o;
   logic [AW-1:0] addr_o;

   int n_chk = 0;
   int n_bad = 0;
   int expv [MAXM];

   always #5 clk = ~clk;

   prune_brev_agen #(.ADDR_W(AW)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .len_i   (len_i),
      .ready_i (ready_i),
      .busy_o  (busy_o),
      .valid_o (valid_o),
      .last_o  (last_o),
      .addr_o  (addr_o)
   );

   function automatic int brev(input int v, input int n);
      int r = 0;
      for (int i = 0; i < n; i++) r = (r << 1) | ((v >> i) & 1);
      return r;
   endfunction

   function automatic int order_of(input int l);
      int n = 0;
      while ((1 << n) < l) n++;
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // mode 0: ready high; 1: irregular backpressure; 2: ready high + restart attempt
   task automatic run_pkt(input int l, input int mode);
      int n, m, got, cyc, kk;
      int seq_err, first_bad_act, first_bad_exp, last_err, gap_err, hold_err, pow_err;
      bit prev_stall, pow2;
      logic [AW-1:0] prev_addr;
      n = order_of(l);
      m = 1 << n;
      pow2 = (m == l);
      kk = 0;
      for (int j = 0; j < m; j++) begin
         if (brev(j, n) < l) begin
            expv[kk] = brev(j, n);
            kk++;
         end
      end
      seq_err = 0; last_err = 0; gap_err = 0; hold_err = 0; pow_err = 0;
      first_bad_act = 0; first_bad_exp = 0;
      prev_stall = 0; prev_addr = '0;
      ready_i = 1'b1;
      start_i = 1'b1;
      len_i = (AW + 1)'(l);
      @(negedge clk);
      start_i = 1'b0;
      // R10: accepted on this edge, busy now, no address yet
      check(busy_o && !valid_o, "R10 latency", {busy_o, valid_o}, 2);
      @(negedge clk);
      got = 0;
      cyc = 0;
      while (got < l && cyc < 8 * MAXM + 20) begin
         ready_i = (mode == 1) ? ((cyc % 3) != 1 && (cyc % 7) != 4) : 1'b1;
         if (mode == 2) begin
            start_i = (cyc == 2 || cyc == 3);
            len_i   = (AW + 1)'((l == 2) ? 5 : 2);
         end
         if (prev_stall && !(valid_o && addr_o == prev_addr)) hold_err++;
         if (mode != 1 && !valid_o) gap_err++;
         if (valid_o && ready_i) begin
            if (int'(addr_o) != expv[got]) begin
               if (seq_err == 0) begin
                  first_bad_act = int'(addr_o);
                  first_bad_exp = expv[got];
               end
               seq_err++;
            end
            if (pow2 && int'(addr_o) != brev(got, n)) pow_err++;
            if (last_o != (got == l - 1)) last_err++;
            got++;
         end
         prev_stall = valid_o && !ready_i;
         prev_addr = addr_o;
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      ready_i = 1'b1;
      check(seq_err == 0, $sformatf("R1 R2 order L=%0d mode=%0d", l, mode), first_bad_act, first_bad_exp);
      check(got == l, $sformatf("R3 count L=%0d", l), got, l);
      check(last_err == 0, $sformatf("R3 last flag L=%0d", l), last_err, 0);
      check(!busy_o && !valid_o, $sformatf("R3 idle after L=%0d", l), {busy_o, valid_o}, 0);
      if (pow2) check(pow_err == 0, $sformatf("R8 full permutation L=%0d", l), pow_err, 0);
      if (mode == 0) check(gap_err == 0, $sformatf("R4 no gap L=%0d", l), gap_err, 0);
      if (mode == 1) check(hold_err == 0, $sformatf("R5 stall hold L=%0d", l), hold_err, 0);
      if (mode == 2) check(seq_err == 0 && gap_err == 0, $sformatf("R6 restart ignored L=%0d", l), seq_err + gap_err, 0);
   endtask

   task automatic try_bad_len(input int l);
      int seen = 0;
      start_i = 1'b1;
      len_i = (AW + 1)'(l);
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (busy_o || valid_o) seen++;
         @(negedge clk);
      end
      check(seen == 0, $sformatf("R7 illegal length %0d", l), seen, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R9: reset state
      check(!valid_o && !last_o && !busy_o, "R9 reset", {valid_o, last_o, busy_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!valid_o && !busy_o, "R9 after release", {valid_o, busy_o}, 0);

      for (int l = 2; l <= MAXM; l++) run_pkt(l, 0);

      run_pkt(2, 1);
      run_pkt(3, 1);
      run_pkt(5, 1);
      run_pkt(17, 1);
      run_pkt(32, 1);
      run_pkt(33, 1);
      run_pkt(MAXM, 1);

      run_pkt(7, 2);
      run_pkt(40, 2);
      run_pkt(MAXM, 2);
      run_pkt(2, 2);

      try_bad_len(0);
      try_bad_len(1);
      try_bad_len(MAXM + 1);
      try_bad_len(2 * MAXM - 1);

      run_pkt(33, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule